// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block merges the interrupt sources of one serial channel into a single interrupt request line and a 4-bit status code. The five sources are line-status error, receive data ready, receive timeout, transmit holding register empty and modem-line change. Line status, receive data and receive timeout are level inputs that the owning logic holds until its own condition goes away. The transmit-empty source is held here as a pending flag. The modem-line changes are held here as four delta bits.

Each source class has its own enable bit. The status code always reports the highest-priority enabled source that is pending. A host read of the status code acknowledges the transmit-empty source, but only while that source is the one being reported. A host read of the modem status clears the delta bits. The interrupt line is the registered OR of every enabled pending source, so it carries no glitches from the status logic.

Top module: `uic_top`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, `isr_code` is 4'b0001, `modem_delta` is 0 and no transmit-empty interrupt is pending.
- R2: The enable bits map as follows:
  - `ier[0]` gates receive data and receive timeout.
  - `ier[1]` gates transmit empty.
  - `ier[2]` gates line status.
  - `ier[3]` gates modem change.

  A source whose enable bit is 0 has no effect on `isr_code` or `irq`.
- R3: `isr_code` reflects the current inputs and state in the same cycle. It shows the highest enabled pending source, in this order: line status 4'b0110, then receive data 4'b0100 or receive timeout 4'b1100, then transmit empty 4'b0010, then modem change 4'b0000. When nothing is pending it shows 4'b0001.
- R4: Within the receive level, receive data (4'b0100) takes precedence over receive timeout (4'b1100).
- R5: `irq` in cycle n+1 is 1 exactly when `isr_code` in cycle n is not 4'b0001.
- R6: A low-to-high transition of `thr_empty` sets the transmit-empty pending flag. The flag is visible in `isr_code` in the cycle after the transition is sampled. A steady high level does not set it again.
- R7: The transmit-empty flag is cleared by `thr_write`, or by `isr_rd` in a cycle where `isr_code` is 4'b0010. A new rising edge in the same cycle wins over the clear.
- R8: `isr_rd` in a cycle where `isr_code` is not 4'b0010 leaves the transmit-empty flag unchanged.
- R9: `modem_delta[0]`, `[1]` and `[3]` are set when their `modem_in` bit changes in either direction. `modem_delta[2]` (the ring input) is set only by a high-to-low change.
- R10: `msr_rd` clears all delta bits. A bit whose input change is sampled in the same cycle stays set. Delta bits are otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier | input | 4 | Source enables (rx, tx empty, line status, modem) |
| line_err | input | 1 | Line-status error level |
| rx_ready | input | 1 | Receive data ready level |
| rx_timeout | input | 1 | Receive timeout level |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_write | input | 1 | Write strobe to the transmit holding register |
| modem_in | input | 4 | Modem inputs, bit 2 is ring |
| isr_rd | input | 1 | Host read strobe of the status code |
| msr_rd | input | 1 | Host read strobe of the modem status |
| irq | output | 1 | Registered interrupt request |
| isr_code | output | 4 | Current status code |
| modem_delta | output | 4 | Modem change bits |

## Verification
The assertions assume that the modem inputs and `thr_empty` are already synchronous to `clk`. They also assume that `isr_rd` and `msr_rd` are single-cycle strobes sampled at the same edge as the state they acknowledge.

The stimulus changes every input only at the falling edge. Read strobes, writes and level changes are drawn at random with fixed-seed biases, so that coincident set-and-clear cycles occur often. Directed sequences add the ring edge polarity, read-while-outranked and reset cases.

// File: rtl/uic_pkg.sv
// Package: shared status codes and source indices for the UART
// interrupt prioritizer. Assumes a 4-bit status code whose bit 0 is high
// only when nothing is pending.
package uic_pkg;
    localparam int CODE_W = 4;
    localparam int NSRC   = 5;

    // Source indices, 0 = highest priority
    localparam int SRC_LS   = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_RXTO = 2;
    localparam int SRC_THRE = 3;
    localparam int SRC_MS   = 4;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;
    localparam logic [CODE_W-1:0] CODE_LS   = 4'b0110;
    localparam logic [CODE_W-1:0] CODE_RXD  = 4'b0100;
    localparam logic [CODE_W-1:0] CODE_RXTO = 4'b1100;
    localparam logic [CODE_W-1:0] CODE_THRE = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_MS   = 4'b0000;

    // Map a source index to its status code
    function automatic logic [CODE_W-1:0] code_of(input int idx);
        case (idx)
            SRC_LS:   code_of = CODE_LS;
            SRC_RXD:  code_of = CODE_RXD;
            SRC_RXTO: code_of = CODE_RXTO;
            SRC_THRE: code_of = CODE_THRE;
            default:  code_of = CODE_MS;
        endcase
    endfunction
endpackage

// File: rtl/uic_modem_delta.sv
// Module: modem change detector. Holds one delta bit per modem input.
// A bit is set on a change of its input; the bit at FALL_IDX is set only
// on a high-to-low change. A read strobe clears all bits, and a
// change in the same cycle wins over the clear. Assumes synchronous inputs.
module uic_modem_delta #(
    parameter int NMODEM   = 4,
    parameter int FALL_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NMODEM-1:0] modem_in,
    input  logic              msr_rd,
    output logic [NMODEM-1:0] delta
);
    logic [NMODEM-1:0] prev_q;
    logic [NMODEM-1:0] chg;

    // Per-bit change detect; polarity picked per bit by generate
    for (genvar i = 0; i < NMODEM; i++) begin : g_bit
        if (i == FALL_IDX) begin : g_fall
            assign chg[i] = prev_q[i] & ~modem_in[i];
        end else begin : g_any
            assign chg[i] = prev_q[i] ^ modem_in[i];
        end
    end

    // Track previous input; loaded with the live value in reset so no false delta
    always_ff @(posedge clk) begin
        prev_q <= modem_in;
    end

    // Delta bits: set on change, cleared on read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta <= '0;
        end else begin
            for (int i = 0; i < NMODEM; i++) begin
                if (chg[i])      delta[i] <= 1'b1;
                else if (msr_rd) delta[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uic_thre_track.sv
// Module: transmit-empty pending flag. Sets on a rising edge of the
// empty level; clears on a holding-register write or on a status read
// while this source is the one reported. A new edge wins over a clear.
module uic_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thr_write,
    input  logic isr_rd,
    input  logic reported,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = thr_empty & ~prev_q;

    // Previous empty level; reset loads the live level so no edge is seen
    always_ff @(posedge clk) begin
        prev_q <= thr_empty;
    end

    // Pending flag update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)                               pend <= 1'b0;
        else if (rise)                            pend <= 1'b1;
        else if (thr_write || (isr_rd && reported)) pend <= 1'b0;
    end
endmodule

// File: rtl/uic_prio_enc.sv
// Module: priority encoder. Masks the source vector with the enables
// and reports the code of the lowest-index (highest-priority) source.
module uic_prio_enc
    import uic_pkg::*;
(
    input  logic [NSRC-1:0]   src,
    input  logic [3:0]        ier,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    logic [NSRC-1:0] masked;

    // Enable gating per source class
    always_comb begin
        masked[SRC_LS]   = src[SRC_LS]   & ier[2];
        masked[SRC_RXD]  = src[SRC_RXD]  & ier[0];
        masked[SRC_RXTO] = src[SRC_RXTO] & ier[0];
        masked[SRC_THRE] = src[SRC_THRE] & ier[1];
        masked[SRC_MS]   = src[SRC_MS]   & ier[3];
    end

    // Walk from lowest to highest priority so the highest one wins
    always_comb begin
        code = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (masked[i]) code = code_of(i);
        end
        any = |masked;
    end
endmodule

// File: rtl/uic_top.sv
// Module: UART interrupt prioritizer top. Combines the level sources,
// the transmit-empty flag and the modem deltas into a status code and a
// registered interrupt line. Assumes all inputs are synchronous to clk.
module uic_top
    import uic_pkg::*;
#(
    parameter int NMODEM   = 4,
    parameter int RING_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ier,
    input  logic              line_err,
    input  logic              rx_ready,
    input  logic              rx_timeout,
    input  logic              thr_empty,
    input  logic              thr_write,
    input  logic [NMODEM-1:0] modem_in,
    input  logic              isr_rd,
    input  logic              msr_rd,
    output logic              irq,
    output logic [3:0]        isr_code,
    output logic [NMODEM-1:0] modem_delta
);
    logic            thre_pend;
    logic            any_pend;
    logic [NSRC-1:0] src;

    uic_modem_delta #(.NMODEM(NMODEM), .FALL_IDX(RING_IDX)) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .modem_in (modem_in),
        .msr_rd   (msr_rd),
        .delta    (modem_delta)
    );

    uic_thre_track u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .thr_write (thr_write),
        .isr_rd    (isr_rd),
        .reported  (isr_code == CODE_THRE),
        .pend      (thre_pend)
    );

    // Assemble the source vector in priority order
    always_comb begin
        src[SRC_LS]   = line_err;
        src[SRC_RXD]  = rx_ready;
        src[SRC_RXTO] = rx_timeout;
        src[SRC_THRE] = thre_pend;
        src[SRC_MS]   = |modem_delta;
    end

    uic_prio_enc u_prio (
        .src  (src),
        .ier  (ier),
        .code (isr_code),
        .any  (any_pend)
    );

    // Glitch-free interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_pend;
    end
endmodule

// File: rtl/uic_checker.sv
// Module: property checker for uic_top, attached by bind.
module uic_checker #(
    parameter int NMODEM = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ier,
    input logic              line_err,
    input logic              rx_ready,
    input logic              thr_empty,
    input logic              thr_write,
    input logic [NMODEM-1:0] modem_in,
    input logic              msr_rd,
    input logic              irq,
    input logic [3:0]        isr_code,
    input logic [NMODEM-1:0] modem_delta
);
    // R5: line follows the code one cycle later
    a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_code != 4'b0001) |=> irq);
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_code == 4'b0001) |=> !irq);

    // R3: only legal codes appear
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        isr_code inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});

    // R3: enabled line status outranks everything
    a_r3_ls_top: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && ier[2]) |-> isr_code == 4'b0110);

    // R4: receive data outranks timeout
    a_r4_rx_over_to: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && ier[0] && !(line_err && ier[2])) |-> isr_code == 4'b0100);

    // R2: all sources disabled gives the idle code
    a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b0000) |-> isr_code == 4'b0001);

    // R10: a read with no input change empties the delta bits
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && modem_in == $past(modem_in)) |=> modem_delta == '0);

    // R7: a write without a new edge leaves no transmit-empty code
    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && !(thr_empty && !$past(thr_empty))) |=> isr_code != 4'b0010);
endmodule

bind uic_top uic_checker #(.NMODEM(NMODEM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier         (ier),
    .line_err    (line_err),
    .rx_ready    (rx_ready),
    .thr_empty   (thr_empty),
    .thr_write   (thr_write),
    .modem_in    (modem_in),
    .msr_rd      (msr_rd),
    .irq         (irq),
    .isr_code    (isr_code),
    .modem_delta (modem_delta)
);

// File: tb/sim_uic_top.sv
`timescale 1ns/1ps
module sim_uic_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ier;
    logic       line_err, rx_ready, rx_timeout, thr_empty, thr_write;
    logic [3:0] modem_in;
    logic       isr_rd, msr_rd;
    logic       irq;
    logic [3:0] isr_code;
    logic [3:0] modem_delta;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic       m_thre;
    logic       m_prev_e;
    logic [3:0] m_delta;
    logic [3:0] m_prev_m;
    logic       m_irq;

    uic_top u0 (
        .clk(clk), .rst_n(rst_n), .ier(ier), .line_err(line_err),
        .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
        .thr_write(thr_write), .modem_in(modem_in), .isr_rd(isr_rd),
        .msr_rd(msr_rd), .irq(irq), .isr_code(isr_code), .modem_delta(modem_delta)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] exp_code();
        if (ier[2] && line_err)    return 4'b0110;
        if (ier[0] && rx_ready)    return 4'b0100;
        if (ier[0] && rx_timeout)  return 4'b1100;
        if (ier[1] && m_thre)      return 4'b0010;
        if (ier[3] && |m_delta)    return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare outputs against the model, then advance the model by one edge
    task automatic cycle(input string req);
        logic [3:0] c;
        #1;
        c = exp_code();
        check(req, "isr_code", isr_code, c);
        check("R5", "irq", irq, m_irq);
        check("R9", "modem_delta", modem_delta, m_delta);
        m_irq = (c != 4'b0001);
        if (thr_empty && !m_prev_e)                       m_thre = 1'b1;
        else if (thr_write || (isr_rd && c == 4'b0010))   m_thre = 1'b0;
        m_prev_e = thr_empty;
        for (int i = 0; i < 4; i++) begin
            logic ch;
            ch = (i == 2) ? (m_prev_m[i] && !modem_in[i]) : (m_prev_m[i] != modem_in[i]);
            if (ch)          m_delta[i] = 1'b1;
            else if (msr_rd) m_delta[i] = 1'b0;
        end
        m_prev_m = modem_in;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        line_err = 0; rx_ready = 0; rx_timeout = 0; thr_write = 0;
        isr_rd = 0; msr_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; ier = 4'hF; idle_inputs(); thr_empty = 1; modem_in = 4'b0100;
        repeat (3) @(negedge clk);
        m_thre = 0; m_prev_e = thr_empty; m_delta = 0; m_prev_m = modem_in; m_irq = 0;
        #1;
        // R1: reset state
        check("R1", "irq", irq, 0);
        check("R1", "isr_code", isr_code, 4'b0001);
        check("R1", "modem_delta", modem_delta, 0);
        rst_n = 1;
        @(negedge clk);
        cycle("R1");
        // R6: rising edge of empty sets pending
        thr_empty = 0; cycle("R6");
        thr_empty = 1; cycle("R6");
        check("R6", "thre code", isr_code, 4'b0010);
        // R8: status read while line status reported keeps THRE
        line_err = 1; isr_rd = 1; cycle("R8");
        line_err = 0; isr_rd = 0; #1;
        check("R8", "thre kept", isr_code, 4'b0010);
        cycle("R8");
        // R7: read while reported clears
        isr_rd = 1; cycle("R7");
        isr_rd = 0; #1;
        check("R7", "thre cleared", isr_code, 4'b0001);
        cycle("R7");
        // R4: data outranks timeout
        rx_ready = 1; rx_timeout = 1; cycle("R4");
        rx_ready = 0; cycle("R4");
        check("R4", "timeout code", isr_code, 4'b1100);
        rx_timeout = 0;
        // R2: disabled line status ignored
        ier = 4'b1011; line_err = 1; cycle("R2");
        line_err = 0; ier = 4'hF;
        // R9: ring rising edge does not set, falling does
        modem_in = 4'b0000; cycle("R9");
        check("R9", "ring fall", modem_delta, 4'b0100);
        msr_rd = 1; cycle("R10");
        msr_rd = 0; modem_in = 4'b0100; cycle("R9");
        check("R9", "ring rise", modem_delta, 4'b0000);
        // R10: change in the read cycle wins
        modem_in = 4'b0101; msr_rd = 1; cycle("R10");
        msr_rd = 0; #1;
        check("R10", "set wins", modem_delta, 4'b0001);
        msr_rd = 1; cycle("R10");
        msr_rd = 0;
        // R3: random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 15) == 0) ier = 4'($urandom);
            line_err   = ($urandom_range(0, 7) == 0);
            rx_ready   = ($urandom_range(0, 5) == 0);
            rx_timeout = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 5) == 0) thr_empty = ~thr_empty;
            thr_write  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) modem_in = 4'($urandom);
            isr_rd     = ($urandom_range(0, 3) == 0);
            msr_rd     = ($urandom_range(0, 5) == 0);
            cycle("R3");
        end
        idle_inputs();
        cycle("R3");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule